// File: doc/BRIEF.md
# Programmable Interrupt Controller

A 32-source interrupt controller for collecting peripheral requests and presenting them to a processor or to another controller. Each source has four configuration bits, each held in its own register: an enable, a polarity, a trigger kind (level or edge) and a fast-path steering bit. Every source input first passes through a two-flop synchroniser. On the synchronised value the block then detects one of four trigger conditions: rising edge, falling edge, high level or low level. Edge events are held in a sticky latch until software acknowledges them. Level sources follow the input directly.

Software reaches the configuration through a simple synchronous write port and a combinational read port. The port is word addressed by byte offset. The block offers two views of the sources: the raw view shows every source, and the status view is the raw view gated by the enables. Software services status bits from the lowest-numbered bit upward.

The block drives two registered request outputs, one for the normal path and one for the fast path. Controllers can be chained: the normal output of one instance goes to source 0 of another.

Top module: `prog_irq_ctrl`

## Requirements
- R1: After reset, the enable, polarity, kind and fast-select registers read zero, so every source is disabled and set to active-low level. Both request outputs are low.
- R2: Register offsets are fixed: enable 0x00, raw 0x04, status 0x08, polarity 0x0C, kind 0x10 and fast-select 0x14. Enable, polarity, kind and fast-select read back what was written. Status is read-only, and a write to it changes nothing. Any other offset, including one with address bits [1:0] not zero, reads as zero.
- R3: In level mode (kind bit 0), the raw bit equals the synchronised input when the polarity bit is 1 and its inverse when the polarity bit is 0. An input change shows in the raw read after two rising clock edges.
- R4: In edge mode (kind bit 1), a polarity bit of 1 latches a rising edge and a polarity bit of 0 latches a falling edge. A transition in the other direction is not latched. The latched bit stays set after the input returns.
- R5: Writing 1 to a raw bit clears that source's edge latch, and writing 0 leaves it as it is. For a source in level mode, writing 1 has no effect.
- R6: An edge event that arrives in the same cycle as a clear of that source leaves the latch set. A clear in any later cycle removes it.
- R7: The status register reads as the raw bits ANDed with the enable bits.
- R8: The normal output goes high one cycle after some status bit whose fast-select bit is 0 is set. The fast output does the same for status bits whose fast-select bit is 1. Both outputs are low while every enable is 0.
- R9: When the normal output of a second instance drives source 0 of an instance with source 0 set to active-high level and enabled, that instance reports status bit 0 and raises its own normal output. Both clear once the second instance's source goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Asynchronous interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Registered normal-path request |
| fiq_o | output | 1 | Registered fast-path request |

## Verification
A table walks the level datapath through several patterns:
- all sources idle, under both polarities;
- a sparse source set with a narrow enable mask;
- the same set with the fast path selected;
- split-polarity words with the enables or the fast-select set on one half.

These patterns separate inversion errors, enable gating, and the steering between the two outputs. Directed sequences then separate the edge modes from the level modes:
- a rising transition seen by a falling-mode source;
- a one-cycle pulse;
- selective acknowledges with zero bits;
- an acknowledge that lands in exactly the cycle the edge arrives, compared with one that lands a cycle later.

A chained second instance checks that a request is passed on through source 0.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int unsigned NSRC = 32;
    localparam int unsigned DW   = 32;
    localparam int unsigned AW   = 5;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        SEL_ENA  = 3'd0,
        SEL_RAW  = 3'd1,
        SEL_STAT = 3'd2,
        SEL_POL  = 3'd3,
        SEL_KIND = 3'd4,
        SEL_FAST = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [NSRC-1:0] ena;
        logic [NSRC-1:0] pol;
        logic [NSRC-1:0] kind;
        logic [NSRC-1:0] fast;
    } cfg_t;

    // Word-aligned decode; misaligned offsets select nothing.
    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        reg_sel_e s;
        if (a[1:0] != 2'b00) begin
            s = SEL_NONE;
        end else begin
            case (a[AW-1:2])
                3'd0:    s = SEL_ENA;
                3'd1:    s = SEL_RAW;
                3'd2:    s = SEL_STAT;
                3'd3:    s = SEL_POL;
                3'd4:    s = SEL_KIND;
                3'd5:    s = SEL_FAST;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pic_detect.sv
module pic_detect #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] kind,
    input  logic [W-1:0] clr,
    output logic [W-1:0] raw
);
    logic [W-1:0] prev_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] ev;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < int'(W); i++) begin : g_src
        assign ev[i] = kind[i] & (pol[i] ? (lvl[i] & ~prev_q[i])
                                         : (~lvl[i] & prev_q[i]));

        // New edge beats a simultaneous acknowledge; level mode holds no latch.
        always_ff @(posedge clk) begin
            if (rst) pend_q[i] <= 1'b0;
            else     pend_q[i] <= kind[i] & (ev[i] | (pend_q[i] & ~clr[i]));
        end

        assign raw[i] = kind[i] ? pend_q[i] : ~(lvl[i] ^ pol[i]);

        assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (rst)
            (pend_q[i] && kind[i] && !clr[i]) |=> pend_q[i]);

        assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
            (!pend_q[i] && !ev[i]) |=> !pend_q[i]);

        assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !ev[i]) |=> !pend_q[i]);

        assert_edge_beats_ack_R6: assert property (@(posedge clk) disable iff (rst)
            (ev[i] && clr[i]) |=> pend_q[i]);
    end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] status,
    output cfg_t            cfg,
    output logic [NSRC-1:0] clr,
    output logic [DW-1:0]   rdata
);
    cfg_t     cfg_q;
    reg_sel_e sel;

    assign sel = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_ENA:  cfg_q.ena  <= wdata;
                SEL_POL:  cfg_q.pol  <= wdata;
                SEL_KIND: cfg_q.kind <= wdata;
                SEL_FAST: cfg_q.fast <= wdata;
                default:  ;
            endcase
        end
    end

    assign clr = (wr && sel == SEL_RAW) ? wdata : '0;

    always_comb begin
        case (sel)
            SEL_ENA:  rdata = cfg_q.ena;
            SEL_RAW:  rdata = raw;
            SEL_STAT: rdata = status;
            SEL_POL:  rdata = cfg_q.pol;
            SEL_KIND: rdata = cfg_q.kind;
            SEL_FAST: rdata = cfg_q.fast;
            default:  rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

    assert_status_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_STAT) |=> $stable(cfg_q));
endmodule

// File: rtl/prog_irq_ctrl.sv
module prog_irq_ctrl
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_in,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_o,
    output logic            fiq_o
);
    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] status;
    cfg_t            cfg;

    pic_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(src_in), .sync_out(lvl)
    );

    pic_detect #(.W(NSRC)) u_det (
        .clk(clk), .rst(rst), .lvl(lvl), .pol(cfg.pol), .kind(cfg.kind),
        .clr(clr), .raw(raw)
    );

    assign status = raw & cfg.ena;

    pic_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .raw(raw), .status(status), .cfg(cfg), .clr(clr), .rdata(bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(status & ~cfg.fast);
            fiq_o <= |(status & cfg.fast);
        end
    end

    assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg.ena == '0) |=> (!irq_o && !fiq_o));

    assert_all_fast_no_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg.fast == '1) |=> !irq_o);

    assert_all_normal_no_fiq_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg.fast == '0) |=> !fiq_o);
endmodule

// File: tb/prog_irq_ctrl_test.sv
`timescale 1ns/1ps
module prog_irq_ctrl_test;
    localparam logic [4:0] A_ENA = 5'h00, A_RAW = 5'h04, A_STAT = 5'h08,
                           A_POL = 5'h0C, A_KIND = 5'h10, A_FAST = 5'h14;

    typedef struct packed {
        logic [31:0] src, pol, ena, fast, raw, stat;
        logic        irq, fiq;
    } vec_t;

    // R3 R7 R8 level-mode vectors; bit 0 of src is left 0 (chained input)
    localparam vec_t VECS [6] = '{
        '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{32'h0000_00F0, 32'hFFFF_FFFF, 32'h0000_0030, 32'h0000_0000, 32'h0000_00F0, 32'h0000_0030, 1'b1, 1'b0},
        '{32'h0000_00F0, 32'hFFFF_FFFF, 32'h0000_0030, 32'h0000_0030, 32'h0000_00F0, 32'h0000_0030, 1'b0, 1'b1},
        '{32'h8000_0000, 32'hFFFF_0000, 32'h8000_0000, 32'h0000_0001, 32'h8000_FFFF, 32'h8000_0000, 1'b1, 1'b0},
        '{32'hA5A5_0000, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h5A5A_0000, 32'h5A5A_0000, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:1] pri_hi = '0;
    logic        p_wr = 1'b0, s_wr = 1'b0;
    logic [4:0]  p_addr = '0, s_addr = '0;
    logic [31:0] p_wdata = '0, s_wdata = '0;
    logic [31:0] p_rdata, s_rdata;
    logic [31:0] s_src = '0;
    logic        p_irq, p_fiq, s_irq, s_fiq;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] d;

    always #4 clk = ~clk;

    prog_irq_ctrl uut (
        .clk(clk), .rst(rst), .src_in({pri_hi, s_irq}), .bus_wr(p_wr),
        .bus_addr(p_addr), .bus_wdata(p_wdata), .bus_rdata(p_rdata),
        .irq_o(p_irq), .fiq_o(p_fiq)
    );

    prog_irq_ctrl sec (
        .clk(clk), .rst(rst), .src_in(s_src), .bus_wr(s_wr),
        .bus_addr(s_addr), .bus_wdata(s_wdata), .bus_rdata(s_rdata),
        .irq_o(s_irq), .fiq_o(s_fiq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit to_sec, input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        if (to_sec) begin s_wr = 1'b1; s_addr = a; s_wdata = v; end
        else        begin p_wr = 1'b1; p_addr = a; p_wdata = v; end
        @(negedge clk);
        p_wr = 1'b0; s_wr = 1'b0;
    endtask

    task automatic rd(input bit from_sec, input logic [4:0] a, output logic [31:0] v);
        if (from_sec) s_addr = a; else p_addr = a;
        #1;
        v = from_sec ? s_rdata : p_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(3);

        // R1 reset state
        rd(0, A_ENA, d);  chk("R1 enable", d, 32'h0);
        rd(0, A_POL, d);  chk("R1 polarity", d, 32'h0);
        rd(0, A_KIND, d); chk("R1 kind", d, 32'h0);
        rd(0, A_FAST, d); chk("R1 fast", d, 32'h0);
        rd(0, A_RAW, d);  chk("R1 raw active-low idle", d, 32'hFFFF_FFFF);
        chk("R1 irq", {31'b0, p_irq}, 32'h0);
        chk("R1 fiq", {31'b0, p_fiq}, 32'h0);

        // R2 register map
        wr(0, A_ENA, 32'h1234_5678); rd(0, A_ENA, d); chk("R2 enable readback", d, 32'h1234_5678);
        wr(0, A_FAST, 32'hCAFE_0001); rd(0, A_FAST, d); chk("R2 fast readback", d, 32'hCAFE_0001);
        wr(0, A_STAT, 32'hFFFF_FFFF); rd(0, A_ENA, d); chk("R2 status write ignored", d, 32'h1234_5678);
        rd(0, A_STAT, d); chk("R2 status unchanged", d, 32'h1234_5678);
        rd(0, 5'h18, d); chk("R2 unmapped reads zero", d, 32'h0);
        rd(0, 5'h02, d); chk("R2 misaligned reads zero", d, 32'h0);

        // R3 R7 R8 vector table
        for (int i = 0; i < 6; i++) begin
            wr(0, A_KIND, 32'h0);
            wr(0, A_POL, VECS[i].pol);
            wr(0, A_ENA, VECS[i].ena);
            wr(0, A_FAST, VECS[i].fast);
            pri_hi = VECS[i].src[31:1];
            idle(4);
            rd(0, A_RAW, d);  chk($sformatf("R3 raw vec%0d", i), d, VECS[i].raw);
            rd(0, A_STAT, d); chk($sformatf("R7 status vec%0d", i), d, VECS[i].stat);
            chk($sformatf("R8 irq vec%0d", i), {31'b0, p_irq}, {31'b0, VECS[i].irq});
            chk($sformatf("R8 fiq vec%0d", i), {31'b0, p_fiq}, {31'b0, VECS[i].fiq});
        end

        // R3 two-edge latency: level-high on bit 12
        wr(0, A_POL, 32'h0000_1000);
        pri_hi = '0;
        idle(3);
        pri_hi[12] = 1'b1;
        @(posedge clk); #1; rd(0, A_RAW, d); chk("R3 not yet after one edge", d & 32'h1000, 32'h0);
        @(posedge clk); #1; rd(0, A_RAW, d); chk("R3 visible after two edges", d & 32'h1000, 32'h1000);
        pri_hi[12] = 1'b0;

        // R4 edge modes: bit3 rising, bit7 falling
        @(negedge clk);
        wr(0, A_FAST, 32'h0);
        wr(0, A_POL, 32'h0000_0008);
        wr(0, A_ENA, 32'h0000_0088);
        wr(0, A_KIND, 32'h0000_0088);
        idle(3);
        rd(0, A_RAW, d); chk("R4 no latch when idle", d & 32'h88, 32'h0);
        pri_hi[7] = 1'b1; idle(4);
        rd(0, A_RAW, d); chk("R4 rising ignored in falling mode", d & 32'h80, 32'h0);
        pri_hi[7] = 1'b0; idle(4);
        rd(0, A_RAW, d); chk("R4 falling latched", d & 32'h80, 32'h80);
        pri_hi[3] = 1'b1; idle(1); pri_hi[3] = 1'b0; idle(4);
        rd(0, A_RAW, d); chk("R4 rising pulse latched and held", d & 32'h88, 32'h88);
        chk("R8 irq from edge", {31'b0, p_irq}, 32'h1);

        // R5 acknowledges
        wr(0, A_RAW, 32'h0000_0080); idle(1);
        rd(0, A_RAW, d); chk("R5 selective ack", d & 32'h88, 32'h08);
        wr(0, A_RAW, 32'h0000_0008); idle(1);
        rd(0, A_RAW, d); chk("R5 second ack", d & 32'h88, 32'h0);
        chk("R8 irq drops after ack", {31'b0, p_irq}, 32'h0);
        // bit10 is level active-low with input low: raw 1, ack ignored
        wr(0, A_RAW, 32'h0000_0400); idle(1);
        rd(0, A_RAW, d); chk("R5 ack on level source ignored", d & 32'h400, 32'h400);

        // R6 edge and ack in the same cycle
        pri_hi[3] = 1'b1;   // sampled at edge k; event present between k+1 and k+2
        idle(2);
        p_wr = 1'b1; p_addr = A_RAW; p_wdata = 32'h8;
        idle(1); p_wr = 1'b0;
        rd(0, A_RAW, d); chk("R6 edge wins over same-cycle ack", d & 32'h8, 32'h8);
        pri_hi[3] = 1'b0; idle(4);
        wr(0, A_RAW, 32'h0000_0008);
        pri_hi[3] = 1'b1;
        idle(3);
        p_wr = 1'b1; p_addr = A_RAW; p_wdata = 32'h8;
        idle(1); p_wr = 1'b0;
        rd(0, A_RAW, d); chk("R6 later ack clears", d & 32'h8, 32'h0);
        pri_hi[3] = 1'b0;

        // R9 cascade through source 0
        wr(0, A_KIND, 32'h0);
        wr(0, A_FAST, 32'h0);
        wr(0, A_POL, 32'h0000_0001);
        wr(0, A_ENA, 32'h0000_0001);
        wr(1, A_POL, 32'h0000_0020);
        wr(1, A_ENA, 32'h0000_0020);
        idle(4);
        rd(0, A_STAT, d); chk("R9 idle chain", d, 32'h0);
        s_src[5] = 1'b1; idle(10);
        chk("R9 secondary irq", {31'b0, s_irq}, 32'h1);
        rd(0, A_STAT, d); chk("R9 primary status bit0", d, 32'h1);
        chk("R9 primary irq", {31'b0, p_irq}, 32'h1);
        s_src[5] = 1'b0; idle(10);
        rd(0, A_STAT, d); chk("R9 chain released", d, 32'h0);
        chk("R9 primary irq low", {31'b0, p_irq}, 32'h0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule